// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Status

This block is the receive half of an asynchronous serial port. The input line passes through a synchronizer first. A falling edge on the synchronized line starts a frame. The line is then sampled once per bit, in the middle of the bit, using an oversampling tick supplied from outside the block. A frame is made up of a start bit, the data bits sent least significant first, an optional parity bit and one stop bit. At the end of each frame the receiver raises a one-cycle interrupt pulse. If the receive buffer is free, the new byte is placed in it.

There are three sticky error flags. A parity mismatch or a low stop bit sets its flag when the frame is accepted. If a frame completes while the buffer still holds unread data, the overrun flag is set and the new frame is thrown away, so the old buffer contents are kept. Software clears the error flags with a two-step sequence: it reads the status, then reads the buffer. A buffer read on its own only frees the buffer.

Top module: `uart_rx_err`

## Requirements
- R1: With `cfg_seven`=0, a frame loads all 8 data bits into `rx_data`. The first data bit after the start bit goes to bit 0.
- R2: With `cfg_seven`=1, 7 data bits are received into `rx_data[6:0]` and `rx_data[7]` reads 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 expects an even number of ones across the data and parity bits, and `cfg_par_odd`=1 expects an odd number. A mismatch sets `flag_perr` when the frame is accepted.
- R4: A 0 sampled in the stop-bit position sets `flag_ferr` when the frame is accepted.
- R5: A frame that completes while `buf_full`=1 sets `flag_oerr`. That frame is discarded: `rx_data`, `flag_perr` and `flag_ferr` keep their values.
- R6: Every completed frame, including a discarded one, produces `rx_irq` high for exactly one clock cycle. The buffer and the flags update on that same cycle.
- R7: The error flags clear only on a `buf_rd` that follows a `stat_rd` made while at least one flag was set. A `buf_rd` with no such status read leaves the flags unchanged.
- R8: A `stat_rd` made while no flag is set does not arm the clear. A later `buf_rd` then leaves any flags raised in the meantime in place.
- R9: `buf_full` goes to 1 when a frame loads the buffer and returns to 0 on `buf_rd`.
- R10: A low pulse shorter than half a bit period is rejected as a start bit. No interrupt is produced and the buffer is untouched.
- R11: After reset, `rx_data`, all flags, `buf_full` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversampling tick, OSR ticks per bit |
| rxd | input | 1 | Serial input, idle high |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stat_rd | input | 1 | Status read strobe |
| buf_rd | input | 1 | Buffer read strobe |
| rx_data | output | 8 | Receive buffer |
| flag_perr | output | 1 | Parity error flag |
| flag_ferr | output | 1 | Framing error flag |
| flag_oerr | output | 1 | Overrun error flag |
| buf_full | output | 1 | Buffer holds unread data |
| rx_irq | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench builds the receiver with OSR=8 instead of the default 16 and drives a tick every second clock, so one bit lasts 16 clocks. This keeps each frame short enough to run every data width, parity sense, stop-bit error, overrun and clear ordering in one run. The mid-bit sample point of 4 ticks gives a definite threshold for the short start-glitch test. The synchronizer stays at two stages.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_DW = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             perr;
    logic             ferr;
  } rx_frame_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      os_tick,
  input  logic      rx_s,
  input  logic      cfg_seven,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  output logic      fr_done,
  output rx_frame_t fr
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(RX_DW);

  rx_state_e        st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [RX_DW-1:0] sh;
  logic             pacc;
  logic             rx_prev;
  logic             bit_end, half_end, last_bit;

  always_comb begin
    bit_end  = os_tick && (cnt == CW'(OSR - 1));
    half_end = os_tick && (cnt == CW'(HALF - 1));
    last_bit = (bidx == (cfg_seven ? BW'(RX_DW - 2) : BW'(RX_DW - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      pacc    <= 1'b0;
      rx_prev <= 1'b1;
      fr_done <= 1'b0;
      fr      <= '0;
    end else begin
      fr_done <= 1'b0;
      rx_prev <= rx_s;
      case (st)
        RX_IDLE: begin
          if (rx_prev && !rx_s) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end
        RX_START: begin
          if (half_end) begin
            cnt  <= '0;
            bidx <= '0;
            pacc <= 1'b0;
            st   <= rx_s ? RX_IDLE : RX_DATA;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[RX_DW-1:1]};
            pacc <= pacc ^ rx_s;
            bidx <= bidx + 1'b1;
            if (last_bit) st <= cfg_par_en ? RX_PAR : RX_STOP;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_end) begin
            cnt  <= '0;
            pacc <= pacc ^ rx_s;
            st   <= RX_STOP;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt     <= '0;
            fr_done <= 1'b1;
            fr.data <= cfg_seven ? {1'b0, sh[RX_DW-1:1]} : sh;
            fr.perr <= cfg_par_en & (pacc ^ cfg_par_odd);
            fr.ferr <= ~rx_s;
            st      <= RX_IDLE;
          end else if (os_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fr_done,
  input  rx_frame_t        fr,
  input  logic             stat_rd,
  input  logic             buf_rd,
  output logic [RX_DW-1:0] rx_data,
  output logic             flag_perr,
  output logic             flag_ferr,
  output logic             flag_oerr,
  output logic             buf_full,
  output logic             rx_irq
);
  logic armed;
  logic any_flag;

  assign any_flag = flag_perr | flag_ferr | flag_oerr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      flag_perr <= 1'b0;
      flag_ferr <= 1'b0;
      flag_oerr <= 1'b0;
      buf_full  <= 1'b0;
      rx_irq    <= 1'b0;
      armed     <= 1'b0;
    end else begin
      rx_irq <= fr_done;
      if (buf_rd && armed) begin
        flag_perr <= 1'b0;
        flag_ferr <= 1'b0;
        flag_oerr <= 1'b0;
        armed     <= 1'b0;
      end
      if (stat_rd && any_flag) armed <= 1'b1;
      if (fr_done) begin
        if (buf_full) begin
          flag_oerr <= 1'b1;
        end else begin
          rx_data  <= fr.data;
          buf_full <= 1'b1;
          if (fr.perr) flag_perr <= 1'b1;
          if (fr.ferr) flag_ferr <= 1'b1;
        end
      end else if (buf_rd) begin
        buf_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             rxd,
  input  logic             cfg_seven,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             stat_rd,
  input  logic             buf_rd,
  output logic [RX_DW-1:0] rx_data,
  output logic             flag_perr,
  output logic             flag_ferr,
  output logic             flag_oerr,
  output logic             buf_full,
  output logic             rx_irq
);
  logic      rx_s;
  logic      fr_done;
  rx_frame_t fr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(rxd), .d_out(rx_s)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_s(rx_s),
    .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .fr_done(fr_done), .fr(fr)
  );

  uart_rx_regs u_regs (
    .clk(clk), .rst(rst), .fr_done(fr_done), .fr(fr),
    .stat_rd(stat_rd), .buf_rd(buf_rd),
    .rx_data(rx_data), .flag_perr(flag_perr), .flag_ferr(flag_ferr),
    .flag_oerr(flag_oerr), .buf_full(buf_full), .rx_irq(rx_irq)
  );
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
  input logic       clk,
  input logic       rst,
  input logic       buf_rd,
  input logic [7:0] rx_data,
  input logic       flag_perr,
  input logic       flag_ferr,
  input logic       flag_oerr,
  input logic       buf_full,
  input logic       rx_irq
);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && $past(buf_full)) |-> (flag_oerr && $stable(rx_data)));

  assert_full_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(buf_rd) && !rx_irq) |-> !buf_full);

  assert_full_set_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !$past(buf_full)) |-> buf_full);

  assert_perr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_perr) |-> $past(buf_rd));

  assert_ferr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_ferr) |-> $past(buf_rd));

  assert_oerr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_oerr) |-> $past(buf_rd));

  assert_ferr_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_ferr) |-> rx_irq);

  assert_perr_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_perr) |-> rx_irq);
endmodule

bind uart_rx_err uart_rx_err_chk u_chk (
  .clk(clk), .rst(rst), .buf_rd(buf_rd), .rx_data(rx_data),
  .flag_perr(flag_perr), .flag_ferr(flag_ferr), .flag_oerr(flag_oerr),
  .buf_full(buf_full), .rx_irq(rx_irq)
);

// File: tb/uart_rx_err_tb.sv
module uart_rx_err_tb;
  localparam int OSR  = 8;
  localparam int TDIV = 2;
  localparam int BITC = OSR * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic stat_rd = 1'b0, buf_rd = 1'b0;
  logic [7:0] rx_data;
  logic flag_perr, flag_ferr, flag_oerr, buf_full, rx_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int tcnt = 0;
  int irq_cnt = 0;
  int sent_cnt = 0;

  logic [9:0] expq[$];
  logic [7:0] m_data = '0;
  logic m_perr = 0, m_ferr = 0, m_oerr = 0, m_full = 0, m_arm = 0;
  logic ps_stat = 0, ps_buf = 0, prev_irq = 0;
  bit   mon_on = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  uart_rx_err #(.OSR(OSR), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .stat_rd(stat_rd), .buf_rd(buf_rd), .rx_data(rx_data),
    .flag_perr(flag_perr), .flag_ferr(flag_ferr), .flag_oerr(flag_oerr),
    .buf_full(buf_full), .rx_irq(rx_irq)
  );

  always @(posedge clk) begin
    tcnt    <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    os_tick <= (tcnt == TDIV - 1);
    cycles  <= cycles + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, advanced on every falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      logic any;
      any = m_perr | m_ferr | m_oerr;
      if (ps_buf && m_arm) begin
        m_perr = 0; m_ferr = 0; m_oerr = 0; m_arm = 0;
      end
      if (ps_stat && any) m_arm = 1;
      if (rx_irq) begin
        irq_cnt++;
        chk(!prev_irq, "R6 pulse width", 1, 0);
        if (expq.size() == 0) begin
          chk(0, "R6 unexpected irq", 1, 0);
        end else begin
          logic [9:0] f;
          f = expq.pop_front();
          if (m_full) m_oerr = 1;
          else begin
            m_data = f[9:2]; m_full = 1;
            m_perr |= f[1]; m_ferr |= f[0];
          end
        end
      end else if (ps_buf) begin
        m_full = 0;
      end
      chk(rx_data == m_data, "R1 model data", rx_data, m_data);
      chk({flag_perr, flag_ferr, flag_oerr} == {m_perr, m_ferr, m_oerr},
          "R7 model flags", {flag_perr, flag_ferr, flag_oerr}, {m_perr, m_ferr, m_oerr});
      chk(buf_full == m_full, "R9 model full", buf_full, m_full);
      prev_irq = rx_irq;
      ps_stat  = stat_rd;
      ps_buf   = buf_rd;
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse_stat();
    @(posedge clk); #1 stat_rd = 1;
    @(posedge clk); #1 stat_rd = 0;
    wait_clk(2);
  endtask

  task automatic pulse_buf();
    @(posedge clk); #1 buf_rd = 1;
    @(posedge clk); #1 buf_rd = 0;
    wait_clk(2);
  endtask

  task automatic send(input logic [7:0] d, input bit seven, input bit pen,
                      input bit odd, input bit flip, input bit stopv);
    logic [7:0] dm;
    logic par;
    int nb;
    nb = seven ? 7 : 8;
    dm = seven ? {1'b0, d[6:0]} : d;
    par = (^dm) ^ odd ^ flip;
    expq.push_back({dm, pen & flip, ~stopv});
    sent_cnt++;
    @(posedge clk); #1;
    cfg_seven = seven; cfg_par_en = pen; cfg_par_odd = odd;
    rxd = 0; wait_clk(BITC);
    for (int i = 0; i < nb; i++) begin
      rxd = dm[i]; wait_clk(BITC);
    end
    if (pen) begin rxd = par; wait_clk(BITC); end
    rxd = stopv; wait_clk(BITC);
    rxd = 1; wait_clk(2 * BITC);
  endtask

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(1);
    // R11 reset state
    chk({rx_data, flag_perr, flag_ferr, flag_oerr, buf_full, rx_irq} == '0,
        "R11 reset", {rx_data, flag_perr, flag_ferr, flag_oerr, buf_full}, 0);
    mon_on = 1;

    send(8'hA5, 0, 0, 0, 0, 1);
    chk(rx_data == 8'hA5, "R1 lsb first", rx_data, 8'hA5);
    chk(buf_full, "R9 full set", buf_full, 1);
    pulse_buf();
    chk(!buf_full, "R9 full clear", buf_full, 0);

    send(8'h3C, 0, 1, 0, 0, 1);
    chk(!flag_perr && rx_data == 8'h3C, "R3 even ok", flag_perr, 0);
    pulse_buf();
    send(8'hC3, 0, 1, 0, 1, 1);
    chk(flag_perr, "R3 even mismatch", flag_perr, 1);
    pulse_buf();
    chk(flag_perr, "R7 buf read alone", flag_perr, 1);
    pulse_stat();
    pulse_buf();
    chk(!flag_perr, "R7 clear sequence", flag_perr, 0);

    send(8'h55, 1, 1, 1, 0, 1);
    chk(rx_data == 8'h55 && !flag_perr, "R2 seven odd", rx_data, 8'h55);
    pulse_buf();
    send(8'hFF, 1, 0, 0, 0, 1);
    chk(rx_data == 8'h7F, "R2 top bit zero", rx_data, 8'h7F);
    pulse_buf();
    send(8'h0E, 1, 1, 1, 1, 1);
    chk(flag_perr, "R3 odd mismatch", flag_perr, 1);
    pulse_stat(); pulse_buf();

    send(8'h81, 0, 0, 0, 0, 0);
    chk(flag_ferr && rx_data == 8'h81, "R4 stop low", flag_ferr, 1);
    wait_clk(BITC);
    pulse_stat(); pulse_buf();
    chk(!flag_ferr, "R4 cleared", flag_ferr, 0);

    send(8'h11, 0, 0, 0, 0, 1);
    send(8'h22, 0, 1, 0, 1, 0);
    chk(flag_oerr && rx_data == 8'h11, "R5 overrun keeps", rx_data, 8'h11);
    chk(!flag_perr && !flag_ferr, "R5 dropped flags", {flag_perr, flag_ferr}, 0);
    chk(irq_cnt == sent_cnt, "R6 irq count", irq_cnt, sent_cnt);
    wait_clk(BITC);
    pulse_stat(); pulse_buf();
    chk(!flag_oerr && !buf_full, "R7 oerr cleared", flag_oerr, 0);

    pulse_stat();
    send(8'h42, 0, 0, 0, 0, 0);
    wait_clk(BITC);
    pulse_buf();
    chk(flag_ferr, "R8 idle status no arm", flag_ferr, 1);
    pulse_stat(); pulse_buf();

    @(posedge clk); #1 rxd = 0;
    wait_clk(4);
    rxd = 1;
    wait_clk(3 * BITC);
    chk(irq_cnt == sent_cnt && !buf_full, "R10 glitch rejected", irq_cnt, sent_cnt);
    send(8'h5A, 0, 0, 0, 0, 1);
    chk(rx_data == 8'h5A, "R10 after glitch", rx_data, 8'h5A);
    chk(irq_cnt == sent_cnt, "R6 final count", irq_cnt, sent_cnt);

    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) @(posedge clk);
    if (!done) chk(0, "watchdog", cycles, 0);
    mon_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule